// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggers

This block is one bank of 32 general-purpose pins placed behind a plain 32-bit register bus: an address, a write strobe, write data and a combinational read-data return. Software drives the pins through an output value register and a direction register. Single bits of the output can be changed without a read-modify-write through a set port and a clear port that take one bits as commands.

Each input pin passes through a two-flop synchronizer. When a pin's filter is enabled, it then passes through a debounce stage that samples on ticks of a shared, programmable prescaler. The resulting value feeds a trigger unit. Three per-pin configuration bits pick rising edge, falling edge, both edges, high level or low level. Edge events are held in a raw status register until software acknowledges them. Level events track the pin. A masked view, raw status AND enable AND NOT mask, is ORed into a single interrupt line, so a handler can scan the masked view to find its sources.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset every readable register returns 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: A write to offset 0x00 sets the output value, which appears on `pin_out` and reads back at 0x00. A write to 0x08 sets the direction, where bit value 1 means output, and it appears on `pin_oe`.
- R3: A write to 0x10 sets the output bits whose write-data bit is 1, and a write to 0x14 clears them. Zero bits leave the output unchanged, and both offsets read as 0.
- R4: Offset 0x04 returns the synchronized pins. A change on `pin_in` is visible there after the second rising clock edge, and not after the first.
- R5: The trigger select bits are level (0x34), both-edge (0x38) and polarity (0x3C). With level=0 and both=0, polarity 0 latches a rising edge into raw status (0x24) and polarity 1 latches a falling edge. The opposite edge latches nothing.
- R6: With level=0 and both=1, either edge latches raw status, whatever the polarity.
- R7: With level=1, the raw status bit equals the filtered pin XOR polarity, so polarity 0 means active high and polarity 1 means active low. An acknowledge has no lasting effect while the level is active.
- R8: A latched edge status bit stays set until a 1 is written to its bit of the acknowledge register at 0x30. Zero bits in that write leave status unchanged.
- R9: Masked status (0x28) equals raw AND enable (0x20) AND NOT mask (0x2C), and `irq` is the OR of masked status.
- R10: For a pin with debounce enabled (0x40), the filtered input takes a new value only after two consecutive prescaler ticks sample it. A pulse shorter than one tick period never reaches the trigger logic.
- R11: The prescaler ticks once every (prescale+1) clocks, with the prescale value at 0x44. With prescale 0, a debounced rising edge appears in raw status after the fifth rising clock edge following the pin change, and not after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pin inputs |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a debounced glitch that lands between prescaler ticks. The bench cannot see the prescaler's phase, so it chooses a pulse width and a prescale value for which no phase can give two qualifying ticks. It then checks that nothing latched. To check the opposite case, it holds the pin and samples after a number of cycles that brackets the earliest and latest possible latch. Every trigger mode is driven from a table that pairs a starting and a final level for one pin. The bench acknowledges between the two levels, so only the final transition can show up in raw status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int DW  = 32;
    localparam int AW  = 8;

    localparam logic [AW-1:0] A_OUTVAL  = 8'h00;
    localparam logic [AW-1:0] A_PINVAL  = 8'h04;
    localparam logic [AW-1:0] A_DIR     = 8'h08;
    localparam logic [AW-1:0] A_SETB    = 8'h10;
    localparam logic [AW-1:0] A_CLRB    = 8'h14;
    localparam logic [AW-1:0] A_IEN     = 8'h20;
    localparam logic [AW-1:0] A_RAW     = 8'h24;
    localparam logic [AW-1:0] A_PEND    = 8'h28;
    localparam logic [AW-1:0] A_MASK    = 8'h2C;
    localparam logic [AW-1:0] A_ACK     = 8'h30;
    localparam logic [AW-1:0] A_LVLSEL  = 8'h34;
    localparam logic [AW-1:0] A_ANYEDGE = 8'h38;
    localparam logic [AW-1:0] A_POL     = 8'h3C;
    localparam logic [AW-1:0] A_DBEN    = 8'h40;
    localparam logic [AW-1:0] A_DBDIV   = 8'h44;

    // Returns the edge events selected by the per-pin edge configuration.
    function automatic logic [DW-1:0] edge_hit(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] prev,
                                               input logic [DW-1:0] any_edge,
                                               input logic [DW-1:0] pol);
        logic [DW-1:0] rise, fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        return (any_edge & (rise | fall)) | (~any_edge & ~pol & rise) |
               (~any_edge & pol & fall);
    endfunction
endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
    parameter int NPIN = 32,
    parameter int PSW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] db_en,
    input  logic [PSW-1:0]  div_i,
    output logic [NPIN-1:0] sync_o,
    output logic [NPIN-1:0] filt_o
);
    logic [NPIN-1:0] s1_q, s2_q, hold_q, deb_q;
    logic [PSW-1:0]  cnt_q;
    logic            tick;

    assign tick = (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= '0;
            s2_q  <= '0;
            cnt_q <= '0;
        end else begin
            s1_q  <= pin_i;
            s2_q  <= s1_q;
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[i] <= 1'b0;
                deb_q[i]  <= 1'b0;
            end else if (tick) begin
                hold_q[i] <= s2_q[i];
                if (s2_q[i] == hold_q[i] && s2_q[i] != deb_q[i])
                    deb_q[i] <= s2_q[i];
            end
        end
        assign filt_o[i] = db_en[i] ? deb_q[i] : s2_q[i];
    end

    assign sync_o = s2_q;

    a_r10_deb_moves_on_tick_only: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(deb_q));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] filt_i,
    input  logic [NPIN-1:0] lvl_sel,
    input  logic [NPIN-1:0] any_edge,
    input  logic [NPIN-1:0] pol,
    input  logic [NPIN-1:0] ack_i,
    output logic [NPIN-1:0] raw_o
);
    import gpio_bank_pkg::*;

    logic [NPIN-1:0] prev_q, raw_q, hit, lvl_act;
    logic [DW-1:0]   hit_w;

    assign hit_w   = edge_hit(DW'(filt_i), DW'(prev_q), DW'(any_edge), DW'(pol));
    assign hit     = hit_w[NPIN-1:0];
    assign lvl_act = filt_i ^ pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            raw_q  <= '0;
        end else begin
            prev_q <= filt_i;
            raw_q  <= (lvl_sel & lvl_act) | (~lvl_sel & ((raw_q & ~ack_i) | hit));
        end
    end

    assign raw_o = raw_q;

    a_r8_edge_status_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(raw_q) & ~$past(ack_i) & ~$past(lvl_sel) & ~raw_q) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int NPIN = 32,
    parameter int PSW  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic        irq
);
    import gpio_bank_pkg::*;

    logic [NPIN-1:0] out_q, dir_q, ien_q, mask_q, lvl_q, any_q, pol_q, dben_q;
    logic [PSW-1:0]  div_q;
    logic [NPIN-1:0] sync_v, filt_v, raw_v, pend_v, ack_v, wd;

    assign wd    = bus_wdata[NPIN-1:0];
    assign ack_v = (bus_we && bus_addr == A_ACK) ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            ien_q  <= '0;
            mask_q <= '0;
            lvl_q  <= '0;
            any_q  <= '0;
            pol_q  <= '0;
            dben_q <= '0;
            div_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_OUTVAL:  out_q  <= wd;
                A_DIR:     dir_q  <= wd;
                A_SETB:    out_q  <= out_q | wd;
                A_CLRB:    out_q  <= out_q & ~wd;
                A_IEN:     ien_q  <= wd;
                A_MASK:    mask_q <= wd;
                A_LVLSEL:  lvl_q  <= wd;
                A_ANYEDGE: any_q  <= wd;
                A_POL:     pol_q  <= wd;
                A_DBEN:    dben_q <= wd;
                A_DBDIV:   div_q  <= bus_wdata[PSW-1:0];
                default: ;
            endcase
        end
    end

    gpio_in_filter #(.NPIN(NPIN), .PSW(PSW)) u_filt (
        .clk(clk), .rst(rst), .pin_i(pin_in[NPIN-1:0]), .db_en(dben_q),
        .div_i(div_q), .sync_o(sync_v), .filt_o(filt_v)
    );

    gpio_irq_unit #(.NPIN(NPIN)) u_irq (
        .clk(clk), .rst(rst), .filt_i(filt_v), .lvl_sel(lvl_q),
        .any_edge(any_q), .pol(pol_q), .ack_i(ack_v), .raw_o(raw_v)
    );

    assign pend_v = raw_v & ien_q & ~mask_q;
    assign irq    = |pend_v;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_OUTVAL:  bus_rdata[NPIN-1:0] = out_q;
            A_PINVAL:  bus_rdata[NPIN-1:0] = sync_v;
            A_DIR:     bus_rdata[NPIN-1:0] = dir_q;
            A_IEN:     bus_rdata[NPIN-1:0] = ien_q;
            A_RAW:     bus_rdata[NPIN-1:0] = raw_v;
            A_PEND:    bus_rdata[NPIN-1:0] = pend_v;
            A_MASK:    bus_rdata[NPIN-1:0] = mask_q;
            A_LVLSEL:  bus_rdata[NPIN-1:0] = lvl_q;
            A_ANYEDGE: bus_rdata[NPIN-1:0] = any_q;
            A_POL:     bus_rdata[NPIN-1:0] = pol_q;
            A_DBEN:    bus_rdata[NPIN-1:0] = dben_q;
            A_DBDIV:   bus_rdata[PSW-1:0]  = div_q;
            default:   bus_rdata = '0;
        endcase
    end

    always_comb begin
        pin_out = '0;
        pin_oe  = '0;
        pin_out[NPIN-1:0] = out_q;
        pin_oe[NPIN-1:0]  = dir_q;
    end

    a_r3_set_port_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SETB) |=> ((out_q & $past(wd)) == $past(wd)));
    a_r3_clr_port_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLRB) |=> ((out_q & $past(wd)) == '0));
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(ien_q & ~mask_q)));
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {level, both, polarity, start level, end level, expected raw bit}
    localparam logic [5:0] TRIG_TBL [10] = '{
        6'b000_011, 6'b000_100, 6'b001_101, 6'b001_010, 6'b010_011,
        6'b011_101, 6'b100_011, 6'b100_100, 6'b101_101, 6'b101_010
    };
    localparam int TP = 5;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        foreach (TRIG_TBL[i]) begin end
        for (int a = 0; a <= 8'h44; a += 4) begin
            rd(8'(a), v);
            chk($sformatf("R1 reg %02h", a), v, 32'h0);
        end
        chk("R1 outputs", {pin_out[0], pin_oe[0], irq, 29'h0} | (pin_out | pin_oe), 32'h0);

        // R2 output value and direction
        wr(8'h00, 32'hA5A5_0F0F);
        rd(8'h00, v);
        chk("R2 out readback", v, 32'hA5A5_0F0F);
        chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        wr(8'h08, 32'hFFFF_0000);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);

        // R3 set/clear ports
        wr(8'h10, 32'h0000_00F0);
        chk("R3 set", pin_out, 32'hA5A5_0FFF);
        wr(8'h14, 32'h0F0F_0000);
        chk("R3 clear", pin_out, 32'hA0A0_0FFF);
        rd(8'h10, v);
        chk("R3 set port reads 0", v, 32'h0);
        rd(8'h14, v);
        chk("R3 clear port reads 0", v, 32'h0);

        // R4 synchronizer latency
        pin_in[20] = 1'b1;
        step(1);
        rd(8'h04, v);
        chk("R4 after one edge", v[20], 1'b0);
        step(1);
        rd(8'h04, v);
        chk("R4 after two edges", v[20], 1'b1);

        // R5 R6 R7 trigger table
        for (int i = 0; i < 10; i++) begin
            logic [5:0] e;
            string tag;
            e = TRIG_TBL[i];
            tag = e[5] ? "R7 level" : (e[4] ? "R6 both" : "R5 edge");
            wr(8'h34, 32'(e[5]) << TP);
            wr(8'h38, 32'(e[4]) << TP);
            wr(8'h3C, 32'(e[3]) << TP);
            pin_in[TP] = e[2];
            step(4);
            wr(8'h30, 32'hFFFF_FFFF);
            pin_in[TP] = e[1];
            step(4);
            rd(8'h24, v);
            chk($sformatf("%s entry %0d", tag, i), v[TP], e[0]);
        end

        // R7 acknowledge has no lasting effect on active level
        wr(8'h34, 32'h1 << TP);
        wr(8'h3C, 32'h0);
        pin_in[TP] = 1'b1;
        step(4);
        wr(8'h30, 32'h1 << TP);
        step(1);
        rd(8'h24, v);
        chk("R7 level survives ack", v[TP], 1'b1);
        wr(8'h34, 32'h0);
        pin_in[TP] = 1'b0;
        step(4);
        wr(8'h30, 32'hFFFF_FFFF);

        // R8 sticky edge and W1C
        pin_in[12] = 1'b1;
        step(4);
        rd(8'h24, v);
        chk("R8 edge latched", v[12], 1'b1);
        wr(8'h30, 32'hFFFF_EFFF);
        rd(8'h24, v);
        chk("R8 zero ack bit keeps", v[12], 1'b1);
        wr(8'h30, 32'h0000_1000);
        rd(8'h24, v);
        chk("R8 ack clears", v[12], 1'b0);

        // R9 masked status and irq
        pin_in[3] = 1'b1;
        step(4);
        rd(8'h28, v);
        chk("R9 disabled pend", v, 32'h0);
        chk("R9 disabled irq", 32'(irq), 32'h0);
        wr(8'h20, 32'h8);
        rd(8'h28, v);
        chk("R9 enabled pend", v, 32'h8);
        chk("R9 enabled irq", 32'(irq), 32'h1);
        wr(8'h2C, 32'h8);
        rd(8'h28, v);
        chk("R9 masked pend", v, 32'h0);
        chk("R9 masked irq", 32'(irq), 32'h0);

        // R10 debounce
        wr(8'h44, 32'd3);
        wr(8'h40, 32'h0000_0180);
        step(12);
        wr(8'h30, 32'hFFFF_FFFF);
        pin_in[7] = 1'b1;
        step(3);
        pin_in[7] = 1'b0;
        step(12);
        rd(8'h24, v);
        chk("R10 glitch filtered", v[7], 1'b0);
        pin_in[7] = 1'b1;
        step(5);
        rd(8'h24, v);
        chk("R10 not yet debounced", v[7], 1'b0);
        step(12);
        rd(8'h24, v);
        chk("R10 held input passes", v[7], 1'b1);

        // R11 prescale 0
        wr(8'h44, 32'd0);
        step(4);
        pin_in[8] = 1'b1;
        step(4);
        rd(8'h24, v);
        chk("R11 before fifth edge", v[8], 1'b0);
        step(1);
        rd(8'h24, v);
        chk("R11 after fifth edge", v[8], 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule